// File: doc/BRIEF.md
# Dual-Stage Watchdog Timer with Write Unlock

This block is a watchdog that software arms and then has to service at regular intervals. Its countdown runs in two stages, one after the other. The first stage counts down from its own preload value. When it runs out, the block can raise an interrupt, and it then loads the second stage from a separate preload value. If the second stage also runs out, the block raises a system reset request and sets a timeout flag. That flag is cleared only by power-on reset or on purpose by software, so after a reboot software can see that the watchdog fired.

A prescaler divides the bus clock to make the decrement tick. One of two power-of-two rates is selected at run time. The preload registers and the reload register are guarded: a write to any of them takes effect only right after a two-write unlock sequence. A lock bit stops software from turning the watchdog off once it has been armed. A free-running timer mode reuses the first stage as a periodic interrupt source. The current count and stage can always be read back.

Top module: `dual_stage_wdog`

## Requirements
- R1: After reset, `rst_req` and `irq` are 0, the control word (index 4) reads 0, and the count word (index 6) reads the stage-one preload reset value (default 15360).
- R2: A write to the stage-one preload (index 0), the stage-two preload (index 1) or the reload word (index 3) takes effect only when the two writes just before it were 0x80 and then 0x86, both to index 3. Any other write to these registers leaves them unchanged.
- R3: If any other write comes between 0x80 and 0x86, the unlock is cancelled. Each guarded write uses up the unlock, so the next guarded write needs a fresh sequence.
- R4: While enabled, stage one expires P1 ticks after enable or restart. The interrupt type sits in config (index 5) bits 1:0. Type 00 is a level: `irq` goes high at expiry and stays high until status (index 2) bit 0 is cleared by writing 1 to it. Type 01 gives a one-cycle pulse. Types 10 and 11 give no interrupt and do not set the status bit.
- R5: After stage one expires in watchdog mode, stage two loads P2 and expires P2 ticks later. If config bit 5 is set, `rst_req` then goes high and stays high until reset.
- R6: Reload-word bit 9 reads as the timeout flag. The flag is set when stage two expires. It keeps its value through `rst`, is cleared by `por`, and is also cleared by a guarded reload write with bit 9 set.
- R7: A guarded reload write with bit 8 set restarts the count from the stage-one preload and restarts the prescaler phase.
- R8: While control bit 1 (enable) is 0, the count holds the stage-one preload and no stage expires.
- R9: Control bit 0 is the lock, bit 1 is enable and bit 2 is mode. Once the lock is set, writes cannot clear the lock, enable, mode or config bit 5 until `rst`.
- R10: With config bit 2 clear, a tick occurs every 2^DIV_SLOW_LOG2 clocks. With it set, a tick occurs every 2^DIV_FAST_LOG2 clocks.
- R11: With mode set (control bit 2 = 1), stage one reloads itself on expiry and signals each expiry. Stage two never runs and `rst_req` stays 0.
- R12: The count word holds the count in bits 19:0 and, in bit 20, a flag that is 1 while stage two runs. Read data appears in the cycle after `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset; leaves the timeout flag alone |
| por | input | 1 | Synchronous active-high power-on reset; clears everything |
| wr_en | input | 1 | Write strobe, one word per cycle |
| rd_en | input | 1 | Read strobe |
| addr | input | IDX_W (3) | Register word index (byte offset / 4) |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Registered read data |
| irq | output | 1 | Stage-one interrupt, registered |
| rst_req | output | 1 | System reset request, registered and sticky |

## Verification
All timing is counted from the clock edge that captures the enabling write or the restart write, called E. With a tick period of D clocks, ticks fall at edges E+D, E+2D and so on. `irq` therefore changes at E+P1·D, and `rst_req` changes at E+(P1+P2)·D. The bench checks each output at the falling edge just before its due edge, where it must still hold the old value, and again at the falling edge just after, where it must hold the new value. It makes no reads inside such a window, because each bus access uses one edge and would shift the count. Read data is sampled at the falling edge that follows the capturing rising edge.

// File: rtl/dual_stage_wdog_pkg.sv
package dual_stage_wdog_pkg;

  localparam int WORD_PRE1   = 0;
  localparam int WORD_PRE2   = 1;
  localparam int WORD_STAT   = 2;
  localparam int WORD_RELOAD = 3;
  localparam int WORD_CTRL   = 4;
  localparam int WORD_CFG    = 5;
  localparam int WORD_COUNT  = 6;

  localparam logic [7:0] KEY_FIRST  = 8'h80;
  localparam logic [7:0] KEY_SECOND = 8'h86;

  localparam int RLD_KICK_BIT  = 8;
  localparam int RLD_FLAG_BIT  = 9;
  localparam int CTL_LOCK_BIT  = 0;
  localparam int CTL_EN_BIT    = 1;
  localparam int CTL_MODE_BIT  = 2;
  localparam int CFG_BOOT_BIT  = 5;
  localparam int CFG_FAST_BIT  = 2;

  localparam logic [1:0] IRQ_LEVEL = 2'b00;
  localparam logic [1:0] IRQ_PULSE = 2'b01;

  typedef enum logic [1:0] {UL_IDLE, UL_HALF, UL_OPEN} unlock_e;
  typedef enum logic [1:0] {ST_ONE, ST_TWO, ST_DONE} stage_e;

endpackage

// File: rtl/wdog_unlock.sv
module wdog_unlock
  import dual_stage_wdog_pkg::*;
#(
  parameter int IDX_W  = 3,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  output logic              grant
);

  unlock_e state_q;
  logic    is_reload;
  logic    is_guarded;

  assign is_reload  = (wr_idx == IDX_W'(WORD_RELOAD));
  assign is_guarded = is_reload || (wr_idx == IDX_W'(WORD_PRE1)) ||
                      (wr_idx == IDX_W'(WORD_PRE2));
  assign grant      = wr_en && (state_q == UL_OPEN) && is_guarded;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= UL_IDLE;
    end else if (wr_en) begin
      if (state_q == UL_OPEN) begin
        state_q <= UL_IDLE;
      end else if (state_q == UL_HALF && is_reload &&
                   wr_data == DATA_W'(KEY_SECOND)) begin
        state_q <= UL_OPEN;
      end else if (is_reload && wr_data == DATA_W'(KEY_FIRST)) begin
        state_q <= UL_HALF;
      end else begin
        state_q <= UL_IDLE;
      end
    end
  end

  AST_OPEN_NEEDS_KEYS: assert property (@(posedge clk) disable iff (rst)
    (state_q == UL_OPEN && $past(state_q) != UL_OPEN) |->
      ($past(state_q) == UL_HALF && $past(wr_en) && $past(is_reload) &&
       $past(wr_data) == DATA_W'(KEY_SECOND))); // R2

  AST_GRANT_USED_UP: assert property (@(posedge clk) disable iff (rst)
    grant |=> (state_q == UL_IDLE)); // R3

endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int SLOW_LOG2 = 15,
  parameter int FAST_LOG2 = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic clear,
  input  logic fast,
  output logic tick
);

  localparam logic [SLOW_LOG2-1:0] SLOW_MASK = {SLOW_LOG2{1'b1}};
  localparam logic [SLOW_LOG2-1:0] FAST_MASK = SLOW_LOG2'((1 << FAST_LOG2) - 1);

  logic [SLOW_LOG2-1:0] cnt_q;
  logic [SLOW_LOG2-1:0] mask;

  assign mask = fast ? FAST_MASK : SLOW_MASK;
  assign tick = run && ((cnt_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || !run || clear) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick); // R10

endmodule

// File: rtl/wdog_stage_ctr.sv
module wdog_stage_ctr
  import dual_stage_wdog_pkg::*;
#(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic             tick,
  input  logic             periodic,
  input  logic [CNT_W-1:0] pre1,
  input  logic [CNT_W-1:0] pre2,
  output logic [CNT_W-1:0] count,
  output stage_e           stage,
  output logic             s1_exp,
  output logic             s2_exp
);

  logic [CNT_W-1:0] count_q;
  stage_e           stage_q;
  logic             at_end;
  logic             step;

  assign at_end = (count_q <= CNT_W'(1));
  assign step   = run && !restart && tick;
  assign s1_exp = step && (stage_q == ST_ONE) && at_end;
  assign s2_exp = step && (stage_q == ST_TWO) && at_end;
  assign count  = count_q;
  assign stage  = stage_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      stage_q <= ST_ONE;
    end else if (!run || restart) begin
      count_q <= pre1;
      stage_q <= ST_ONE;
    end else if (tick) begin
      case (stage_q)
        ST_ONE: begin
          if (!at_end) begin
            count_q <= count_q - 1'b1;
          end else if (periodic) begin
            count_q <= pre1;
          end else begin
            count_q <= pre2;
            stage_q <= ST_TWO;
          end
        end
        ST_TWO: begin
          if (!at_end) begin
            count_q <= count_q - 1'b1;
          end else begin
            count_q <= '0;
            stage_q <= ST_DONE;
          end
        end
        default: begin
          count_q <= count_q;
        end
      endcase
    end
  end

  AST_IDLE_HOLDS_PRE1: assert property (@(posedge clk) disable iff (rst)
    !run |=> (count_q == $past(pre1) && stage_q == ST_ONE)); // R8

  AST_STAGE_TWO_NEXT: assert property (@(posedge clk) disable iff (rst)
    (s1_exp && !periodic) |=> (stage_q == ST_TWO)); // R5

  AST_TIMER_NO_STAGE2: assert property (@(posedge clk) disable iff (rst)
    (s1_exp && periodic) |=> (stage_q == ST_ONE)); // R11

endmodule

// File: rtl/dual_stage_wdog.sv
module dual_stage_wdog
  import dual_stage_wdog_pkg::*;
#(
  parameter int               IDX_W         = 3,
  parameter int               DATA_W        = 32,
  parameter int               CNT_W         = 20,
  parameter int               DIV_SLOW_LOG2 = 15,
  parameter int               DIV_FAST_LOG2 = 5,
  parameter logic [CNT_W-1:0] PRE1_RST      = 20'h03C00,
  parameter logic [CNT_W-1:0] PRE2_RST      = 20'h03C00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              por,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq,
  output logic              rst_req
);

  localparam int STAGE_BIT = CNT_W;

  logic             rst_any;
  logic             grant;
  logic             tick;
  logic             restart;
  logic             s1_exp, s2_exp;
  logic [CNT_W-1:0] count;
  stage_e           stage;

  logic [CNT_W-1:0]  pre1_q, pre2_q;
  logic              status_q, status_d;
  logic              flag_q;
  logic              lock_q, en_q, mode_q;
  logic              boot_q, fast_q;
  logic [1:0]        itype_q;
  logic              irq_q, rst_req_q;
  logic [DATA_W-1:0] rdata_q, rd_next;

  logic wr_stat, wr_ctrl, wr_cfg, g_pre1, g_pre2, g_rld;

  assign rst_any = rst | por;

  assign wr_stat = wr_en && (addr == IDX_W'(WORD_STAT));
  assign wr_ctrl = wr_en && (addr == IDX_W'(WORD_CTRL));
  assign wr_cfg  = wr_en && (addr == IDX_W'(WORD_CFG));
  assign g_pre1  = grant && (addr == IDX_W'(WORD_PRE1));
  assign g_pre2  = grant && (addr == IDX_W'(WORD_PRE2));
  assign g_rld   = grant && (addr == IDX_W'(WORD_RELOAD));
  assign restart = g_rld && wdata[RLD_KICK_BIT];

  wdog_unlock #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_unlock (
    .clk     (clk),
    .rst     (rst_any),
    .wr_en   (wr_en),
    .wr_idx  (addr),
    .wr_data (wdata),
    .grant   (grant)
  );

  wdog_prescaler #(.SLOW_LOG2(DIV_SLOW_LOG2), .FAST_LOG2(DIV_FAST_LOG2)) u_presc (
    .clk   (clk),
    .rst   (rst_any),
    .run   (en_q),
    .clear (restart),
    .fast  (fast_q),
    .tick  (tick)
  );

  wdog_stage_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk      (clk),
    .rst      (rst_any),
    .run      (en_q),
    .restart  (restart),
    .tick     (tick),
    .periodic (mode_q),
    .pre1     (pre1_q),
    .pre2     (pre2_q),
    .count    (count),
    .stage    (stage),
    .s1_exp   (s1_exp),
    .s2_exp   (s2_exp)
  );

  always_comb begin
    status_d = status_q;
    if (wr_stat && wdata[0]) status_d = 1'b0;
    if (s1_exp && !itype_q[1]) status_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst_any) begin
      pre1_q    <= PRE1_RST;
      pre2_q    <= PRE2_RST;
      status_q  <= 1'b0;
      lock_q    <= 1'b0;
      en_q      <= 1'b0;
      mode_q    <= 1'b0;
      boot_q    <= 1'b0;
      fast_q    <= 1'b0;
      itype_q   <= IRQ_LEVEL;
      irq_q     <= 1'b0;
      rst_req_q <= 1'b0;
    end else begin
      if (g_pre1) pre1_q <= wdata[CNT_W-1:0];
      if (g_pre2) pre2_q <= wdata[CNT_W-1:0];
      status_q <= status_d;
      if (wr_ctrl) begin
        lock_q <= lock_q | wdata[CTL_LOCK_BIT];
        en_q   <= lock_q ? (en_q | wdata[CTL_EN_BIT]) : wdata[CTL_EN_BIT];
        mode_q <= lock_q ? mode_q : wdata[CTL_MODE_BIT];
      end
      if (wr_cfg) begin
        boot_q  <= lock_q ? (boot_q | wdata[CFG_BOOT_BIT]) : wdata[CFG_BOOT_BIT];
        fast_q  <= wdata[CFG_FAST_BIT];
        itype_q <= wdata[1:0];
      end
      if (itype_q == IRQ_LEVEL) begin
        irq_q <= status_d;
      end else if (itype_q == IRQ_PULSE) begin
        irq_q <= s1_exp;
      end else begin
        irq_q <= 1'b0;
      end
      if (s2_exp && boot_q && !mode_q) rst_req_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (por) begin
      flag_q <= 1'b0;
    end else if (s2_exp) begin
      flag_q <= 1'b1;
    end else if (!rst && g_rld && wdata[RLD_FLAG_BIT]) begin
      flag_q <= 1'b0;
    end
  end

  always_comb begin
    rd_next = '0;
    case (addr)
      IDX_W'(WORD_PRE1):   rd_next[CNT_W-1:0] = pre1_q;
      IDX_W'(WORD_PRE2):   rd_next[CNT_W-1:0] = pre2_q;
      IDX_W'(WORD_STAT):   rd_next[0] = status_q;
      IDX_W'(WORD_RELOAD): rd_next[RLD_FLAG_BIT] = flag_q;
      IDX_W'(WORD_CTRL): begin
        rd_next[CTL_LOCK_BIT] = lock_q;
        rd_next[CTL_EN_BIT]   = en_q;
        rd_next[CTL_MODE_BIT] = mode_q;
      end
      IDX_W'(WORD_CFG): begin
        rd_next[CFG_BOOT_BIT] = boot_q;
        rd_next[CFG_FAST_BIT] = fast_q;
        rd_next[1:0]          = itype_q;
      end
      IDX_W'(WORD_COUNT): begin
        rd_next[CNT_W-1:0] = count;
        rd_next[STAGE_BIT] = (stage == ST_TWO);
      end
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst_any) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      rdata_q <= rd_next;
    end
  end

  assign rdata   = rdata_q;
  assign irq     = irq_q;
  assign rst_req = rst_req_q;

  AST_RSTREQ_STICKY: assert property (@(posedge clk) disable iff (rst_any)
    rst_req_q |=> rst_req_q); // R5

  AST_LOCK_STAYS: assert property (@(posedge clk) disable iff (rst_any)
    lock_q |=> lock_q); // R9

  AST_LOCKED_EN_STAYS: assert property (@(posedge clk) disable iff (rst_any)
    (lock_q && en_q) |=> en_q); // R9

  AST_LOCKED_BOOT_STAYS: assert property (@(posedge clk) disable iff (rst_any)
    (lock_q && boot_q) |=> boot_q); // R9

  AST_NO_IRQ_TYPE: assert property (@(posedge clk) disable iff (rst_any)
    itype_q[1] |=> !irq_q); // R4

  AST_FLAG_KEEPS_ON_RST: assert property (@(posedge clk) disable iff (por)
    (rst && flag_q) |=> flag_q); // R6

  AST_TIMER_NO_RESET: assert property (@(posedge clk) disable iff (rst_any)
    (mode_q && !rst_req_q) |=> !rst_req_q); // R11

endmodule

// File: tb/dual_stage_wdog_tb_top.sv
module dual_stage_wdog_tb_top;

  localparam int IDX_W = 3;
  localparam int DW    = 32;
  localparam int LIMIT = 100000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          por = 1'b1;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [IDX_W-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          irq;
  logic          rst_req;

  int nchk = 0;
  int nerr = 0;
  int cyc  = 0;

  always #10 clk = ~clk;

  dual_stage_wdog #(.DIV_SLOW_LOG2(6), .DIV_FAST_LOG2(2)) dut_i (
    .clk(clk), .rst(rst), .por(por), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq), .rst_req(rst_req)
  );

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > LIMIT) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, LIMIT);
      summary();
    end
  end

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic skip(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic bus_wr(input int idx, input logic [DW-1:0] d);
    wr_en = 1'b1; addr = IDX_W'(idx); wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input int idx, output logic [DW-1:0] d);
    rd_en = 1'b1; addr = IDX_W'(idx);
    @(posedge clk);
    @(negedge clk);
    d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic unlock();
    bus_wr(3, 32'h80);
    bus_wr(3, 32'h86);
  endtask

  task automatic prot_wr(input int idx, input logic [DW-1:0] d);
    unlock();
    bus_wr(idx, d);
  endtask

  task automatic pulse_rst(input bit full);
    rst = 1'b1; por = full;
    skip(2);
    rst = 1'b0; por = 1'b0;
    skip(1);
  endtask

  task automatic t_reset();
    logic [DW-1:0] d;
    check("R1 rst_req after reset", rst_req, 0);
    check("R1 irq after reset", irq, 0);
    bus_rd(4, d); check("R1 control reset", d, 0);
    bus_rd(6, d); check("R1 count holds preload", d, 32'd15360);
    bus_rd(3, d); check("R6 flag clear after por", d, 0);
  endtask

  task automatic t_unlock();
    logic [DW-1:0] d;
    bus_wr(0, 32'd5);
    bus_rd(0, d); check("R2 unguarded preload write ignored", d, 32'd15360);
    prot_wr(0, 32'd3);
    bus_rd(0, d); check("R2 guarded preload write taken", d, 32'd3);
    bus_wr(0, 32'd7);
    bus_rd(0, d); check("R3 unlock used up", d, 32'd3);
    bus_wr(3, 32'h80); bus_wr(3, 32'h55); bus_wr(3, 32'h86); bus_wr(0, 32'd9);
    bus_rd(0, d); check("R3 broken sequence cancels", d, 32'd3);
    prot_wr(1, 32'd2);
    bus_rd(1, d); check("R2 stage two preload taken", d, 32'd2);
    bus_rd(6, d); check("R8 R12 idle count equals preload", d, 32'd3);
  endtask

  task automatic t_stage();
    logic [DW-1:0] d;
    bus_wr(5, 32'h24);
    bus_wr(4, 32'h2);
    skip(11); check("R4 irq before stage one end", irq, 0);
    skip(1);  check("R4 irq at stage one end", irq, 1);
    bus_rd(6, d); check("R12 count shows stage two", d, 32'h0010_0002);
    skip(6);  check("R5 rst_req before stage two end", rst_req, 0);
    skip(1);  check("R5 rst_req at stage two end", rst_req, 1);
    skip(3);  check("R5 rst_req held", rst_req, 1);
    bus_rd(3, d); check("R6 flag set on timeout", d, 32'h200);
    bus_rd(2, d); check("R4 status set", d, 1);
    bus_wr(2, 32'h1);
    check("R4 level irq cleared by status write", irq, 0);
    pulse_rst(1'b0);
    check("R5 rst_req cleared by rst", rst_req, 0);
    bus_rd(3, d); check("R6 flag survives rst", d, 32'h200);
    bus_wr(3, 32'h200);
    bus_rd(3, d); check("R6 unguarded clear ignored", d, 32'h200);
    prot_wr(3, 32'h200);
    bus_rd(3, d); check("R6 guarded write clears flag", d, 0);
  endtask

  task automatic t_keepalive();
    logic [DW-1:0] d;
    prot_wr(0, 32'd3);
    prot_wr(1, 32'd2);
    bus_wr(5, 32'h24);
    bus_wr(4, 32'h2);
    skip(5);
    prot_wr(3, 32'h100);
    skip(11); check("R7 no expiry after keepalive", irq, 0);
    skip(1);  check("R7 expiry counted from keepalive", irq, 1);
    bus_wr(4, 32'h0);
    bus_wr(2, 32'h1);
    bus_rd(6, d); check("R8 disabled count reloads preload", d, 32'd3);
    skip(30); check("R8 no expiry while disabled", irq, 0);
  endtask

  task automatic t_freq();
    bus_wr(5, 32'h20);
    bus_wr(4, 32'h2);
    skip(191); check("R10 slow tick irq not yet", irq, 0);
    skip(1);   check("R10 slow tick irq due", irq, 1);
    bus_wr(4, 32'h0);
    bus_wr(2, 32'h1);
    check("R10 irq cleared", irq, 0);
  endtask

  task automatic t_itype();
    logic [DW-1:0] d;
    bus_wr(5, 32'h25);
    bus_wr(4, 32'h2);
    skip(11); check("R4 pulse low before", irq, 0);
    skip(1);  check("R4 pulse high", irq, 1);
    skip(1);  check("R4 pulse one cycle", irq, 0);
    bus_wr(4, 32'h0);
    bus_wr(2, 32'h1);
    bus_wr(5, 32'h27);
    bus_wr(4, 32'h2);
    skip(12); check("R4 no irq for type 11", irq, 0);
    bus_rd(2, d); check("R4 status untouched for type 11", d, 0);
    bus_wr(4, 32'h0);
  endtask

  task automatic t_timer();
    bus_wr(5, 32'h25);
    bus_wr(4, 32'h6);
    skip(12); check("R11 first period", irq, 1);
    skip(1);  check("R11 pulse ends", irq, 0);
    skip(11); check("R11 second period", irq, 1);
    skip(30); check("R11 no reset request", rst_req, 0);
    bus_wr(4, 32'h0);
  endtask

  task automatic t_lock();
    logic [DW-1:0] d;
    bus_wr(5, 32'h27);
    bus_wr(4, 32'h3);
    bus_wr(4, 32'h4);
    bus_rd(4, d); check("R9 lock enable mode held", d, 32'h3);
    bus_wr(5, 32'h04);
    bus_rd(5, d); check("R9 reboot enable held", d, 32'h24);
    skip(40); check("R9 locked watchdog fires", rst_req, 1);
    pulse_rst(1'b0);
    bus_rd(4, d); check("R9 rst releases lock", d, 0);
    bus_rd(3, d); check("R6 flag after locked timeout", d, 32'h200);
    pulse_rst(1'b1);
    bus_rd(3, d); check("R6 por clears flag", d, 0);
  endtask

  initial begin
    skip(3);
    rst = 1'b0; por = 1'b0;
    skip(1);
    t_reset();
    t_unlock();
    t_stage();
    t_keepalive();
    t_freq();
    t_itype();
    t_timer();
    t_lock();
    summary();
  end

endmodule